// File: doc/BRIEF.md
# Token-Passed Candidate Readout Chain

This block gathers track-candidate words from a daisy chain of column stages and delivers them as one unbroken burst at the end of the chain. Every stage owns a local candidate source. The source presents its next word whenever it is not empty and advances when the stage pulses its read strobe. After the final stub of an event's input packet has been accepted, the surrounding logic pulses `start`. From then on, ownership of the output passes down the chain as an end-of-stream token.

Each stage first relays every word that reaches it from the stage before it. When that stage's end-of-stream marker arrives, the stage drains its own source. It tags each word with its own column number and then hands the marker on. A stage with nothing to send hands the marker on in the same cycle slot. The stream that leaves the last stage therefore holds all candidates of the event, ordered by stage, with no idle cycles inside it. A single end-of-stream cycle closes the stream. Candidate storage and the later stub lookup sit outside this block.

Top module: `hsk_chain_readout`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_valid`, `out_eos` and every `loc_rd` bit are low.
- R2: `start` is taken only when no stage is relaying or draining. A `start` pulse during an event leaves that event's output stream unchanged.
- R3: The first output of an event appears exactly NUM_STAGES cycles after the clock edge that takes `start`. This first output is either a word or, for an empty event, the end-of-stream marker.
- R4: Words leave in stage order: all words of stage 0, then all words of stage 1, and so on. `out_col` equals the index of the source stage.
- R5: Each output word carries the row and pointer values that its stage's source presented in the cycle it was read. Within a stage, words keep the order of its source.
- R6: `out_valid` stays high without a break from the first word of an event to its last word.
- R7: `out_eos` is high for exactly one cycle, the cycle directly after the last word. For an event with no words it is the only output of the event.
- R8: `loc_rd[i]` is raised only while `loc_empty[i]` is low, and at most one stage reads in any cycle. By the end of an event every source has been read until it is empty.
- R9: `out_valid` and `out_eos` are never high together. Both stay low between the end-of-stream cycle and the next event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse that begins readout of one event |
| loc_empty | input | NUM_STAGES | Per stage: its local source holds no word |
| loc_row | input | NUM_STAGES*ROW_W | Per stage: phi-row field of the word at the head of the source |
| loc_ptr | input | NUM_STAGES*PTR_W | Per stage: stub pointer of the word at the head of the source |
| loc_rd | output | NUM_STAGES | Per stage: advance the source to its next word |
| out_valid | output | 1 | A candidate word is present on the output |
| out_eos | output | 1 | End-of-stream marker for the current event |
| out_row | output | ROW_W | Phi-row value of the output word |
| out_col | output | $clog2(NUM_STAGES) | Column (stage index) of the output word |
| out_ptr | output | PTR_W | Stub pointer of the output word |

## Verification
The chain is driven with events of several shapes. Events with no words at all show that the bare marker keeps the fixed latency. Events with words only in the first stage or only in the last stage show that the token crosses empty stages without leaving holes. Events where one stage holds a long run check the local drain loop and the marker that follows it. Random sparse and dense fills mix relay and drain across many stage boundaries, and an extra `start` pulse in the middle of a stream shows whether a busy chain wrongly takes a second start.

// File: rtl/hsk_pkg.sv
package hsk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RELAY = 2'd1,
        ST_LOCAL = 2'd2,
        ST_DONE  = 2'd3
    } stage_st_e;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_UP    = 2'd1,
        SEL_LOCAL = 2'd2,
        SEL_EOS   = 2'd3
    } out_sel_e;

endpackage

// File: rtl/hsk_stage_ctrl.sv
module hsk_stage_ctrl
    import hsk_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start_acc,
    input  logic     up_valid,
    input  logic     up_eos,
    input  logic     loc_empty,
    output logic     loc_rd,
    output out_sel_e sel,
    output logic     busy
);

    typedef struct packed {
        stage_st_e st;
    } ctrl_t;

    ctrl_t cur_q, nxt_d;

    always_comb begin
        nxt_d  = cur_q;
        loc_rd = 1'b0;
        sel    = SEL_NONE;
        unique case (cur_q.st)
            ST_IDLE, ST_DONE: begin
                if (start_acc) nxt_d.st = ST_RELAY;
            end
            ST_RELAY: begin
                if (up_eos) begin
                    // token arrives: use its slot for the first local word
                    if (!loc_empty) begin
                        loc_rd   = 1'b1;
                        sel      = SEL_LOCAL;
                        nxt_d.st = ST_LOCAL;
                    end else begin
                        sel      = SEL_EOS;
                        nxt_d.st = ST_DONE;
                    end
                end else if (up_valid) begin
                    sel = SEL_UP;
                end
            end
            ST_LOCAL: begin
                if (!loc_empty) begin
                    loc_rd = 1'b1;
                    sel    = SEL_LOCAL;
                end else begin
                    sel      = SEL_EOS;
                    nxt_d.st = ST_DONE;
                end
            end
            default: nxt_d.st = ST_IDLE;
        endcase
        busy = (cur_q.st == ST_RELAY) || (cur_q.st == ST_LOCAL);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q.st <= ST_IDLE;
        else        cur_q    <= nxt_d;
    end

endmodule

// File: rtl/hsk_stage_dp.sv
module hsk_stage_dp
    import hsk_pkg::*;
#(
    parameter int ROW_W  = 5,
    parameter int COL_W  = 5,
    parameter int PTR_W  = 10,
    parameter int COL_ID = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  out_sel_e         sel,
    input  logic [ROW_W-1:0] up_row,
    input  logic [COL_W-1:0] up_col,
    input  logic [PTR_W-1:0] up_ptr,
    input  logic [ROW_W-1:0] loc_row,
    input  logic [PTR_W-1:0] loc_ptr,
    output logic             dn_valid,
    output logic             dn_eos,
    output logic [ROW_W-1:0] dn_row,
    output logic [COL_W-1:0] dn_col,
    output logic [PTR_W-1:0] dn_ptr
);

    localparam logic [COL_W-1:0] ColTag = COL_W'(COL_ID);

    typedef struct packed {
        logic             valid;
        logic             eos;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic [PTR_W-1:0] ptr;
    } word_t;

    word_t word_q, word_d;

    always_comb begin
        word_d = '0;
        unique case (sel)
            SEL_UP: begin
                word_d.valid = 1'b1;
                word_d.row   = up_row;
                word_d.col   = up_col;
                word_d.ptr   = up_ptr;
            end
            SEL_LOCAL: begin
                word_d.valid = 1'b1;
                word_d.row   = loc_row;
                word_d.col   = ColTag;
                word_d.ptr   = loc_ptr;
            end
            SEL_EOS:  word_d.eos = 1'b1;
            default:  word_d     = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign dn_valid = word_q.valid;
    assign dn_eos   = word_q.eos;
    assign dn_row   = word_q.row;
    assign dn_col   = word_q.col;
    assign dn_ptr   = word_q.ptr;

endmodule

// File: rtl/hsk_stage.sv
module hsk_stage
    import hsk_pkg::*;
#(
    parameter int ROW_W  = 5,
    parameter int COL_W  = 5,
    parameter int PTR_W  = 10,
    parameter int COL_ID = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_acc,
    input  logic             up_valid,
    input  logic             up_eos,
    input  logic [ROW_W-1:0] up_row,
    input  logic [COL_W-1:0] up_col,
    input  logic [PTR_W-1:0] up_ptr,
    input  logic             loc_empty,
    input  logic [ROW_W-1:0] loc_row,
    input  logic [PTR_W-1:0] loc_ptr,
    output logic             loc_rd,
    output logic             dn_valid,
    output logic             dn_eos,
    output logic [ROW_W-1:0] dn_row,
    output logic [COL_W-1:0] dn_col,
    output logic [PTR_W-1:0] dn_ptr,
    output logic             busy
);

    out_sel_e sel;

    hsk_stage_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_acc (start_acc),
        .up_valid  (up_valid),
        .up_eos    (up_eos),
        .loc_empty (loc_empty),
        .loc_rd    (loc_rd),
        .sel       (sel),
        .busy      (busy)
    );

    hsk_stage_dp #(
        .ROW_W  (ROW_W),
        .COL_W  (COL_W),
        .PTR_W  (PTR_W),
        .COL_ID (COL_ID)
    ) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel),
        .up_row   (up_row),
        .up_col   (up_col),
        .up_ptr   (up_ptr),
        .loc_row  (loc_row),
        .loc_ptr  (loc_ptr),
        .dn_valid (dn_valid),
        .dn_eos   (dn_eos),
        .dn_row   (dn_row),
        .dn_col   (dn_col),
        .dn_ptr   (dn_ptr)
    );

endmodule

// File: rtl/hsk_chain_readout.sv
module hsk_chain_readout #(
    parameter int NUM_STAGES = 32,
    parameter int ROW_W      = 5,
    parameter int PTR_W      = 10,
    localparam int COL_W     = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [NUM_STAGES-1:0]       loc_empty,
    input  logic [NUM_STAGES*ROW_W-1:0] loc_row,
    input  logic [NUM_STAGES*PTR_W-1:0] loc_ptr,
    output logic [NUM_STAGES-1:0]       loc_rd,
    output logic                        out_valid,
    output logic                        out_eos,
    output logic [ROW_W-1:0]            out_row,
    output logic [COL_W-1:0]            out_col,
    output logic [PTR_W-1:0]            out_ptr
);

    logic                  ch_valid [NUM_STAGES+1];
    logic                  ch_eos   [NUM_STAGES+1];
    logic [ROW_W-1:0]      ch_row   [NUM_STAGES+1];
    logic [COL_W-1:0]      ch_col   [NUM_STAGES+1];
    logic [PTR_W-1:0]      ch_ptr   [NUM_STAGES+1];
    logic [NUM_STAGES-1:0] busy;

    logic start_acc;
    logic tok_q, tok_d;

    // a new event is taken only when the whole chain is quiet
    always_comb begin
        start_acc = start && !(|busy);
        tok_d     = start_acc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tok_q <= 1'b0;
        else        tok_q <= tok_d;
    end

    assign ch_valid[0] = 1'b0;
    assign ch_eos[0]   = tok_q;
    assign ch_row[0]   = '0;
    assign ch_col[0]   = '0;
    assign ch_ptr[0]   = '0;

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
        hsk_stage #(
            .ROW_W  (ROW_W),
            .COL_W  (COL_W),
            .PTR_W  (PTR_W),
            .COL_ID (g)
        ) u_stage (
            .clk       (clk),
            .rst_n     (rst_n),
            .start_acc (start_acc),
            .up_valid  (ch_valid[g]),
            .up_eos    (ch_eos[g]),
            .up_row    (ch_row[g]),
            .up_col    (ch_col[g]),
            .up_ptr    (ch_ptr[g]),
            .loc_empty (loc_empty[g]),
            .loc_row   (loc_row[g*ROW_W +: ROW_W]),
            .loc_ptr   (loc_ptr[g*PTR_W +: PTR_W]),
            .loc_rd    (loc_rd[g]),
            .dn_valid  (ch_valid[g+1]),
            .dn_eos    (ch_eos[g+1]),
            .dn_row    (ch_row[g+1]),
            .dn_col    (ch_col[g+1]),
            .dn_ptr    (ch_ptr[g+1]),
            .busy      (busy[g])
        );
    end

    assign out_valid = ch_valid[NUM_STAGES];
    assign out_eos   = ch_eos[NUM_STAGES];
    assign out_row   = ch_row[NUM_STAGES];
    assign out_col   = ch_col[NUM_STAGES];
    assign out_ptr   = ch_ptr[NUM_STAGES];

endmodule

// File: rtl/hsk_chain_readout_chk.sv
module hsk_chain_readout_chk #(
    parameter int NUM_STAGES = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_STAGES-1:0] loc_empty,
    input logic [NUM_STAGES-1:0] loc_rd,
    input logic                  out_valid,
    input logic                  out_eos
);

    assert_no_valid_eos_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_eos));

    assert_no_gap_in_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> (out_valid || out_eos));

    assert_eos_single_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_eos |=> !out_eos);

    assert_read_only_nonempty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_rd & loc_empty) == '0);

    assert_single_reader_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(loc_rd));

endmodule

bind hsk_chain_readout hsk_chain_readout_chk #(
    .NUM_STAGES (NUM_STAGES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .loc_empty (loc_empty),
    .loc_rd    (loc_rd),
    .out_valid (out_valid),
    .out_eos   (out_eos)
);

// File: tb/hsk_chain_readout_bench.sv
module hsk_chain_readout_bench;

    localparam int N     = 32;
    localparam int ROW_W = 5;
    localparam int PTR_W = 10;
    localparam int COL_W = $clog2(N);
    localparam int MAXW  = 8;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start = 1'b0;
    logic [N-1:0]        loc_empty;
    logic [N*ROW_W-1:0]  loc_row;
    logic [N*PTR_W-1:0]  loc_ptr;
    logic [N-1:0]        loc_rd;
    logic                out_valid, out_eos;
    logic [ROW_W-1:0]    out_row;
    logic [COL_W-1:0]    out_col;
    logic [PTR_W-1:0]    out_ptr;

    logic [ROW_W-1:0] row_mem [N][MAXW];
    logic [PTR_W-1:0] ptr_mem [N][MAXW];
    int               cnt     [N];
    logic [3:0]       rd_idx  [N];
    logic             q_clr = 1'b0;

    logic [ROW_W-1:0] exp_row [N*MAXW];
    logic [PTR_W-1:0] exp_ptr [N*MAXW];
    logic [COL_W-1:0] exp_col [N*MAXW];

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    hsk_chain_readout #(.NUM_STAGES(N), .ROW_W(ROW_W), .PTR_W(PTR_W)) u_hsk_chain_readout (
        .clk(clk), .rst_n(rst_n), .start(start),
        .loc_empty(loc_empty), .loc_row(loc_row), .loc_ptr(loc_ptr), .loc_rd(loc_rd),
        .out_valid(out_valid), .out_eos(out_eos),
        .out_row(out_row), .out_col(out_col), .out_ptr(out_ptr)
    );

    // show-ahead source model per stage
    always_comb begin
        for (int i = 0; i < N; i++) begin
            loc_empty[i]                 = (int'(rd_idx[i]) >= cnt[i]);
            loc_row[i*ROW_W +: ROW_W]    = row_mem[i][rd_idx[i][2:0]];
            loc_ptr[i*PTR_W +: PTR_W]    = ptr_mem[i][rd_idx[i][2:0]];
        end
    end

    always @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (q_clr)          rd_idx[i] <= '0;
            else if (loc_rd[i]) rd_idx[i] <= rd_idx[i] + 4'd1;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int build_exp();
        int k = 0;
        for (int s = 0; s < N; s++)
            for (int w = 0; w < cnt[s]; w++) begin
                exp_row[k] = row_mem[s][w];
                exp_ptr[k] = ptr_mem[s][w];
                exp_col[k] = COL_W'(s);
                k++;
            end
        return k;
    endfunction

    task automatic clear_srcs();
        for (int s = 0; s < N; s++) begin
            cnt[s] = 0;
            for (int w = 0; w < MAXW; w++) begin
                row_mem[s][w] = ROW_W'($urandom);
                ptr_mem[s][w] = PTR_W'($urandom);
            end
        end
    endtask

    task automatic run_event(input int mid);
        int total;
        int f0;
        f0    = fails;
        total = build_exp();
        @(negedge clk); q_clr = 1'b1;
        @(negedge clk); q_clr = 1'b0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int c = 0; c < N + total + 4; c++) begin
            if (c < N) begin
                chk(!out_valid && !out_eos, "R3", {out_valid, out_eos}, 0);
            end else if (c < N + total) begin
                chk(out_valid && !out_eos, "R6", {out_valid, out_eos}, 2);
                chk(out_row == exp_row[c-N] && out_ptr == exp_ptr[c-N], "R5",
                    {out_row, out_ptr}, {exp_row[c-N], exp_ptr[c-N]});
                chk(out_col == exp_col[c-N], "R4", out_col, exp_col[c-N]);
            end else if (c == N + total) begin
                chk(out_eos && !out_valid, "R7", {out_valid, out_eos}, 1);
            end else begin
                chk(!out_valid && !out_eos, "R9", {out_valid, out_eos}, 0);
            end
            if (c == mid) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int s = 0; s < N; s++)
            chk(int'(rd_idx[s]) == cnt[s], "R8", rd_idx[s], cnt[s]);
        if (mid >= 0)
            chk(fails == f0, "R2", fails - f0, 0);
    endtask

    initial begin
        void'($urandom(32'd2024));
        clear_srcs();
        repeat (3) @(negedge clk);
        chk(!out_valid && !out_eos && loc_rd == '0, "R1", {out_valid, out_eos, loc_rd}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !out_eos && loc_rd == '0, "R1", {out_valid, out_eos, loc_rd}, 0);

        // empty event: marker alone at fixed latency (R7, R3)
        clear_srcs(); run_event(-1);
        // only first stage
        clear_srcs(); cnt[0] = 3; run_event(-1);
        // only last stage
        clear_srcs(); cnt[N-1] = 1; run_event(-1);
        // one long run in a middle stage
        clear_srcs(); cnt[5] = MAXW; run_event(-1);
        // alternating stages
        clear_srcs();
        for (int s = 0; s < N; s += 2) cnt[s] = 2;
        run_event(-1);
        // start pulse in the middle of a busy stream (R2)
        clear_srcs();
        for (int s = 0; s < N; s++) cnt[s] = 1;
        run_event(N / 2);
        clear_srcs(); cnt[3] = 4; cnt[20] = 2; run_event(N + 2);

        // random fills, sparse and dense
        for (int e = 0; e < 24; e++) begin
            clear_srcs();
            for (int s = 0; s < N; s++)
                cnt[s] = ((e % 2) == 0) ? (($urandom_range(0, 4) == 0) ? int'($urandom_range(1, 3)) : 0)
                                        : int'($urandom_range(0, 3));
            run_event(-1);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule